// File: doc/BRIEF.md
# Flash Sector Address Translator

This block sits in front of a NAND-style flash array that uses 2 KB pages, 512-byte sectors and 64 pages per erase block. Firmware programs it through a simple 16-bit register port. There are eight start-address registers and one transfer-setup register. From the block and page registers the block forms linear sector numbers, which a separate sequencer then uses to move data.

Two sector numbers come out continuously. The source sector is built from the block register in slot 0 and the page register in slot 7. The destination sector is built from the destination block in slot 2 and the destination page in slot 3. The block also gives the first sector of the erase unit that the slot-0 block names. Each number has a flag that says whether the whole transfer or erase fits inside the device.

The transfer-setup register holds a 4-bit buffer address and a sector count from one to four. Both are decoded onto output pins.

Top module: `flash_sector_xlat`

## Requirements
- R1: A synchronous active-high reset clears all eight address slots and the buffer address to zero, and sets the sector count to 1.
- R2: A write to offset 0xF100+i, for i from 0 to 7, stores the full 16-bit value in slot i. A read at the same offset returns that value in the same cycle.
- R3: The source sector equals E*256 + page[7:2]*4 + page[1:0]. Here page is slot 7 and E is the effective block formed from slot 0.
- R4: The destination sector uses the same formula, with slot 2 as the block and slot 3 as the page.
- R5: The effective block is block[11:0] OR'd with the density mask when block bit 15 is set. Block bits 14:12 are ignored. The mask is 1<<(6+ID[14:12]) when device-ID bit 11 is set, and zero otherwise.
- R6: The erase base sector is E*256, using the effective block from slot 0. An erase spans 256 sectors.
- R7: A write to offset 0xF200 stores value[11:8] as the buffer address. It also stores value[1:0] as the sector count, where a field of 0 means a count of 4. The count is shown on sector_count.
- R8: A read of 0xF200 returns (buffer address << 8) OR ((count-1) AND 2).
- R9: Buffer address bit 3 drives buf_use_data (data buffers rather than boot buffer). Bit 2 drives buf_index, and bits 1:0 drive buf_sub_sector.
- R10: The source and destination valid flags are high exactly when sector + count is at most the device sector total, 2^(15+ID[14:12]). erase_valid is high exactly when base + 256 is at most that total.
- R11: A write to any other offset changes no register. A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register offset for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| src_sector | output | 24 | Source linear sector number |
| src_valid | output | 1 | Source transfer fits in the device |
| dst_sector | output | 24 | Destination linear sector number |
| dst_valid | output | 1 | Destination transfer fits in the device |
| erase_sector | output | 24 | First sector of the erase unit |
| erase_valid | output | 1 | Erase unit lies inside the device |
| buf_use_data | output | 1 | Data buffers selected instead of the boot buffer |
| buf_index | output | 1 | Which of the two data buffers is used |
| buf_sub_sector | output | 2 | Sector slot within the chosen buffer |
| sector_count | output | 3 | Decoded sector count, 1 to 4 |

## Verification
The bench aims at the last sector of the device. A single-sector transfer there must be valid, while a two-sector transfer must not. An off-by-one range compare would flip one of these two results. Blocks with bit 15 set, together with junk in bits 14:12, expose a design that ignores the density mask or lets the upper bits leak into the sector number. A count field of zero has to read as four, and has to read back with bit 1 set. A design that stores the raw field would report a zero count and a zero bit. Writes to offsets just beside the register window must leave every output unchanged, which catches an over-wide address decode.

// File: rtl/fsat_pkg.sv
package fsat_pkg;

    localparam int SLOT_CNT = 8;
    localparam int REG_W    = 16;
    localparam int BLK_W    = 16;
    localparam int PAGE_IDX_W = 6;
    localparam int SUB_W    = 2;
    localparam int SEC_W    = BLK_W + PAGE_IDX_W + SUB_W;
    localparam int CNT_W    = 3;
    localparam int BUFA_W   = 4;
    localparam int ERASE_SPAN = 1 << (PAGE_IDX_W + SUB_W);

    localparam logic [REG_W-1:0] OFS_SLOT_BASE = 16'hF100;
    localparam logic [REG_W-1:0] OFS_XFER      = 16'hF200;

    typedef enum logic [2:0] {
        SLOT_SRC_BLK  = 3'd0,
        SLOT_DST_BLK  = 3'd2,
        SLOT_DST_PAGE = 3'd3,
        SLOT_SRC_PAGE = 3'd7
    } slot_role_e;

    typedef struct packed {
        logic [BUFA_W-1:0] buf_addr;
        logic [CNT_W-1:0]  count;
    } xfer_cfg_t;

    typedef struct packed {
        logic             use_data;
        logic             index;
        logic [SUB_W-1:0] sub;
    } buf_sel_t;

    typedef logic [SLOT_CNT-1:0][REG_W-1:0] slot_bank_t;

    function automatic logic [BLK_W-1:0] density_mask_of(logic [31:0] id);
        logic [BLK_W-1:0] one;
        one = BLK_W'(1);
        return id[11] ? (one << (6 + int'(id[14:12]))) : '0;
    endfunction

    function automatic int unsigned total_secs_of(logic [31:0] id);
        return 32'd1 << (15 + int'(id[14:12]));
    endfunction

    function automatic logic [BLK_W-1:0] fold_block(logic [REG_W-1:0] b,
                                                    logic [BLK_W-1:0] m);
        return {4'b0, b[11:0]} | (b[15] ? m : '0);
    endfunction

    function automatic logic [CNT_W-1:0] decode_count(logic [1:0] f);
        return (f == 2'd0) ? 3'd4 : {1'b0, f};
    endfunction

    function automatic logic [REG_W-1:0] xfer_readback(xfer_cfg_t c);
        logic [CNT_W-1:0] less_one;
        less_one = c.count - 3'd1;
        return {4'b0, c.buf_addr, 8'b0} | {14'b0, less_one[1], 1'b0};
    endfunction

    function automatic buf_sel_t split_buf(logic [BUFA_W-1:0] a);
        buf_sel_t s;
        s.use_data = a[3];
        s.index    = a[2];
        s.sub      = a[1:0];
        return s;
    endfunction

endpackage

// File: rtl/fsat_regfile.sv
module fsat_regfile
    import fsat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output slot_bank_t       slots,
    output xfer_cfg_t        cfg
);

    localparam logic [REG_W-4:0] SLOT_PAGE_TAG = OFS_SLOT_BASE[REG_W-1:3];

    logic [REG_W-1:0] slot_q [SLOT_CNT];
    logic             in_slot_window;
    logic             at_xfer;

    assign in_slot_window = (reg_addr[REG_W-1:3] == SLOT_PAGE_TAG);
    assign at_xfer        = (reg_addr == OFS_XFER);

    for (genvar i = 0; i < SLOT_CNT; i++) begin : g_slot
        logic hit;
        assign hit = reg_we && in_slot_window && (reg_addr[2:0] == 3'(i));

        always_ff @(posedge clk) begin
            if (rst)
                slot_q[i] <= '0;
            else if (hit)
                slot_q[i] <= reg_wdata;
        end

        assign slots[i] = slot_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.buf_addr <= '0;
            cfg.count    <= 3'd1;
        end else if (reg_we && at_xfer) begin
            cfg.buf_addr <= reg_wdata[11:8];
            cfg.count    <= decode_count(reg_wdata[1:0]);
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (in_slot_window)
            reg_rdata = slot_q[reg_addr[2:0]];
        else if (at_xfer)
            reg_rdata = xfer_readback(cfg);
    end

    // R2: a slot write is visible in the next cycle
    a_r2_slot_write: assert property (@(posedge clk) disable iff (rst)
        (reg_we && in_slot_window) |=> (slots[$past(reg_addr[2:0])] == $past(reg_wdata)))
        else $error("a_r2_slot_write");

    // R7: a zero count field stores four sectors
    a_r7_zero_means_four: assert property (@(posedge clk) disable iff (rst)
        (reg_we && at_xfer && reg_wdata[1:0] == 2'd0) |=> (cfg.count == 3'd4))
        else $error("a_r7_zero_means_four");

    // R7: the stored count is always between 1 and 4
    a_r7_count_legal: assert property (@(posedge clk) disable iff (rst)
        (cfg.count != 3'd0) && (cfg.count <= 3'd4))
        else $error("a_r7_count_legal");

    // R11: writes outside the map leave all state unchanged
    a_r11_unmapped_stable: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !in_slot_window && !at_xfer) |=> ($stable(slots) && $stable(cfg)))
        else $error("a_r11_unmapped_stable");

endmodule

// File: rtl/fsat_sector_calc.sv
module fsat_sector_calc
    import fsat_pkg::*;
#(
    parameter logic [BLK_W-1:0] DENSITY_MASK = '0,
    parameter int unsigned      TOTAL_SECS   = 32'd65536
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] blk_reg,
    input  logic [REG_W-1:0] page_reg,
    input  logic [CNT_W-1:0] count,
    output logic [SEC_W-1:0] sector,
    output logic             in_range
);

    localparam logic [SEC_W+1:0] LIMIT = (SEC_W+2)'(TOTAL_SECS);

    logic [BLK_W-1:0] blk_eff;
    logic [SEC_W-1:0] row;
    logic [SEC_W+1:0] end_excl;
    logic             unused_bits;

    assign unused_bits = ^{page_reg[15:8], blk_reg[14:12]};

    assign blk_eff  = fold_block(blk_reg, DENSITY_MASK);
    assign row      = (SEC_W'(blk_eff) << PAGE_IDX_W) + SEC_W'(page_reg[7:2]);
    assign sector   = (row << SUB_W) + SEC_W'(page_reg[1:0]);
    assign end_excl = (SEC_W+2)'(sector) + (SEC_W+2)'(count);
    assign in_range = (end_excl <= LIMIT);

    // R3 / R4: the low sector bits follow the page register
    a_r3_low_bits: assert property (@(posedge clk) disable iff (rst)
        sector[1:0] == page_reg[1:0])
        else $error("a_r3_low_bits");

    // R10: a valid transfer starts inside the device
    a_r10_start_inside: assert property (@(posedge clk) disable iff (rst)
        in_range |-> ((SEC_W+2)'(sector) < LIMIT))
        else $error("a_r10_start_inside");

endmodule

// File: rtl/fsat_erase_calc.sv
module fsat_erase_calc
    import fsat_pkg::*;
#(
    parameter logic [BLK_W-1:0] DENSITY_MASK = '0,
    parameter int unsigned      TOTAL_SECS   = 32'd65536
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] blk_reg,
    output logic [SEC_W-1:0] base,
    output logic             in_range
);

    localparam logic [SEC_W+1:0] LIMIT = (SEC_W+2)'(TOTAL_SECS);
    localparam logic [SEC_W+1:0] SPAN  = (SEC_W+2)'(ERASE_SPAN);

    logic [BLK_W-1:0] blk_eff;
    logic             unused_bits;

    assign unused_bits = ^blk_reg[14:12];
    assign blk_eff     = fold_block(blk_reg, DENSITY_MASK);
    assign base        = {blk_eff, {(PAGE_IDX_W + SUB_W){1'b0}}};
    assign in_range    = ((SEC_W+2)'(base) + SPAN) <= LIMIT;

    // R6: the erase base's low block-select bits track the block register
    a_r6_base_tracks_block: assert property (@(posedge clk) disable iff (rst)
        base[19:8] == (blk_reg[11:0] | (blk_reg[15] ? DENSITY_MASK[11:0] : 12'd0)))
        else $error("a_r6_base_tracks_block");

    // R10: a valid erase starts inside the device
    a_r10_erase_inside: assert property (@(posedge clk) disable iff (rst)
        in_range |-> ((SEC_W+2)'(base) < LIMIT))
        else $error("a_r10_erase_inside");

endmodule

// File: rtl/flash_sector_xlat.sv
module flash_sector_xlat
    import fsat_pkg::*;
#(
    parameter logic [31:0]      DEVICE_ID    = 32'h0000_1800,
    parameter logic [BLK_W-1:0] DENSITY_MASK = density_mask_of(DEVICE_ID)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [15:0] reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic [23:0] src_sector,
    output logic        src_valid,
    output logic [23:0] dst_sector,
    output logic        dst_valid,
    output logic [23:0] erase_sector,
    output logic        erase_valid,
    output logic        buf_use_data,
    output logic        buf_index,
    output logic [1:0]  buf_sub_sector,
    output logic [2:0]  sector_count
);

    localparam int unsigned TOTAL_SECS = total_secs_of(DEVICE_ID);

    slot_bank_t       slots;
    xfer_cfg_t        cfg;
    buf_sel_t         bsel;
    logic [SEC_W-1:0] path_sec [2];
    logic             path_ok  [2];
    logic             unused_slots;

    assign unused_slots = ^{slots[1], slots[4], slots[5], slots[6]};

    fsat_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .slots     (slots),
        .cfg       (cfg)
    );

    for (genvar p = 0; p < 2; p++) begin : g_path
        localparam slot_role_e BLK_SLOT  = (p == 0) ? SLOT_SRC_BLK  : SLOT_DST_BLK;
        localparam slot_role_e PAGE_SLOT = (p == 0) ? SLOT_SRC_PAGE : SLOT_DST_PAGE;

        fsat_sector_calc #(
            .DENSITY_MASK (DENSITY_MASK),
            .TOTAL_SECS   (TOTAL_SECS)
        ) u_calc (
            .clk      (clk),
            .rst      (rst),
            .blk_reg  (slots[BLK_SLOT]),
            .page_reg (slots[PAGE_SLOT]),
            .count    (cfg.count),
            .sector   (path_sec[p]),
            .in_range (path_ok[p])
        );
    end

    fsat_erase_calc #(
        .DENSITY_MASK (DENSITY_MASK),
        .TOTAL_SECS   (TOTAL_SECS)
    ) u_erase (
        .clk      (clk),
        .rst      (rst),
        .blk_reg  (slots[SLOT_SRC_BLK]),
        .base     (erase_sector),
        .in_range (erase_valid)
    );

    assign src_sector = path_sec[0];
    assign src_valid  = path_ok[0];
    assign dst_sector = path_sec[1];
    assign dst_valid  = path_ok[1];

    assign bsel           = split_buf(cfg.buf_addr);
    assign buf_use_data   = bsel.use_data;
    assign buf_index      = bsel.index;
    assign buf_sub_sector = bsel.sub;
    assign sector_count   = cfg.count;

    // R5/R6: source and erase use the same block, so the source sits inside the erase unit
    a_r6_src_in_erase_unit: assert property (@(posedge clk) disable iff (rst)
        src_sector[23:8] == erase_sector[23:8])
        else $error("a_r6_src_in_erase_unit");

endmodule

// File: tb/flash_sector_xlat_tb_top.sv
module flash_sector_xlat_tb_top;

    localparam logic [31:0] ID = 32'h0000_1800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [23:0] src_sector, dst_sector, erase_sector;
    logic        src_valid, dst_valid, erase_valid;
    logic        buf_use_data, buf_index;
    logic [1:0]  buf_sub_sector;
    logic [2:0]  sector_count;

    always #4 clk = ~clk;

    flash_sector_xlat dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .src_sector(src_sector), .src_valid(src_valid),
        .dst_sector(dst_sector), .dst_valid(dst_valid),
        .erase_sector(erase_sector), .erase_valid(erase_valid),
        .buf_use_data(buf_use_data), .buf_index(buf_index),
        .buf_sub_sector(buf_sub_sector), .sector_count(sector_count)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int m_slot [8];
    int m_buf  = 0;
    int m_cnt  = 1;
    int mask, total;
    int unsigned seed = 32'h2468ACE1;

    function automatic int eff_blk(int b);
        return (b & 'hFFF) | (((b & 'h8000) != 0) ? mask : 0);
    endfunction

    function automatic int sec_of(int b, int p);
        return eff_blk(b) * 256 + ((p / 4) % 64) * 4 + (p % 4);
    endfunction

    function automatic int exp_read(int a);
        if (a >= 'hF100 && a <= 'hF107) return m_slot[a - 'hF100];
        if (a == 'hF200) return (m_buf * 256) + ((m_cnt >= 3) ? 2 : 0);
        return 0;
    endfunction

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        int s, d, e;
        s = sec_of(m_slot[0], m_slot[7]);
        d = sec_of(m_slot[2], m_slot[3]);
        e = eff_blk(m_slot[0]) * 256;
        chk(((m_slot[0] & 'h8000) != 0) ? "R5" : "R3", "src_sector", src_sector, s);
        chk(((m_slot[2] & 'h8000) != 0) ? "R5" : "R4", "dst_sector", dst_sector, d);
        chk("R6", "erase_sector", erase_sector, e);
        chk("R10", "src_valid", src_valid, (s + m_cnt <= total) ? 1 : 0);
        chk("R10", "dst_valid", dst_valid, (d + m_cnt <= total) ? 1 : 0);
        chk("R10", "erase_valid", erase_valid, (e + 256 <= total) ? 1 : 0);
        chk("R7", "sector_count", sector_count, m_cnt);
        chk("R9", "buf_use_data", buf_use_data, (m_buf / 8) % 2);
        chk("R9", "buf_index", buf_index, (m_buf / 4) % 2);
        chk("R9", "buf_sub_sector", buf_sub_sector, m_buf % 4);
    endtask

    // one cycle: drive, check read data, clock, update model, check outputs
    task automatic step(bit r, bit w, int a, int d, string rtag = "");
        string tag;
        @(negedge clk);
        rst = r; reg_we = w; reg_addr = 16'(a); reg_wdata = 16'(d);
        #1;
        if (rtag != "") tag = rtag;
        else if (a >= 'hF100 && a <= 'hF107) tag = "R2";
        else if (a == 'hF200) tag = "R8";
        else tag = "R11";
        chk(tag, "reg_rdata", reg_rdata, exp_read(a));
        @(posedge clk);
        if (r) begin
            foreach (m_slot[k]) m_slot[k] = 0;
            m_buf = 0; m_cnt = 1;
        end else if (w) begin
            if (a >= 'hF100 && a <= 'hF107) m_slot[a - 'hF100] = d & 'hFFFF;
            else if (a == 'hF200) begin
                m_buf = (d / 256) % 16;
                m_cnt = ((d % 4) == 0) ? 4 : (d % 4);
            end
        end
        #2;
        check_outputs();
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        mask  = ((ID >> 11) & 1) ? (1 << (6 + ((ID >> 12) & 7))) : 0;
        total = 1 << (15 + ((ID >> 12) & 7));
        foreach (m_slot[k]) m_slot[k] = 0;

        // R1: reset state, then read all slots back as zero
        step(1, 0, 'hF100, 0);
        step(1, 0, 'hF100, 0);
        for (int i = 0; i < 8; i++) step(0, 0, 'hF100 + i, 0, "R1");
        step(0, 0, 'hF200, 0, "R1");

        // R2/R3: plain source address
        step(0, 1, 'hF100, 'h0005);
        step(0, 1, 'hF107, 'h0037);
        step(0, 0, 'hF107, 0);
        // R5: density flag with junk in bits 14:12
        step(0, 1, 'hF100, 'hF003);
        step(0, 1, 'hF100, 'h7005);
        // R10: last sector of device, count 1 valid then 2 invalid
        step(0, 1, 'hF100, 'h00FF);
        step(0, 1, 'hF107, 'h00FF);
        step(0, 1, 'hF200, 'h0002);
        step(0, 1, 'hF200, 'h0001);
        step(0, 1, 'hF100, 'h807F);
        step(0, 1, 'hF100, 'h0100);
        step(0, 1, 'hF100, 'h8FFF);
        // R4: destination path
        step(0, 1, 'hF102, 'h0042);
        step(0, 1, 'hF103, 'h00C1);
        step(0, 1, 'hF102, 'h80FF);
        // R7/R8/R9: transfer setup encodings
        step(0, 1, 'hF200, 'h0F00);
        step(0, 0, 'hF200, 0);
        step(0, 1, 'hF200, 'h0A02);
        step(0, 0, 'hF200, 0);
        step(0, 1, 'hF200, 'hFC03);
        step(0, 0, 'hF200, 0);
        // R11: writes beside the window change nothing, reads give 0
        step(0, 1, 'hF108, 'hFFFF);
        step(0, 1, 'hF0FF, 'hFFFF);
        step(0, 1, 'hF201, 'h0000);
        step(0, 1, 'h0000, 'h1234);
        step(0, 0, 'hF108, 0);
        // R1: reset mid-run clears everything again
        step(1, 0, 'hF100, 0);
        step(0, 0, 'hF107, 0, "R1");

        for (int i = 0; i < 200; i++) begin
            int unsigned x, kind;
            x = rnd();
            kind = x % 8;
            if (kind < 4) begin
                int idx;
                idx = int'((x >> 4) % 8);
                if (((x >> 8) & 1) != 0) step(0, 1, 'hF100 + idx, int'((x >> 9) & 'h81FF));
                else step(0, 1, 'hF100 + idx, int'((x >> 9) & 'hFFFF));
            end else if (kind == 4) begin
                step(0, 1, 'hF200, int'((x >> 4) & 'hFFFF));
            end else if (kind == 5) begin
                step(0, 1, 'hF108 | int'((x >> 4) & 'h00F0), int'((x >> 8) & 'hFFFF));
            end else begin
                if (((x >> 4) & 1) != 0) step(0, 0, 'hF200, 0);
                else step(0, 0, 'hF100 + int'((x >> 5) % 8), 0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule